// File: doc/BRIEF.md
# Prescaled Interval Timer with Pin Clock Select

This block is an 8-bit up-counter that measures fixed intervals. A free-running prescaler divides the system clock. A 3-bit field in the mode register picks one of eight prescaler taps, and that tap paces the counter. Each time the count passes 0xFF it wraps to 0x00 and keeps counting. The wrap sets a sticky request flag, which software clears by writing a zero to it. An interrupt line follows the flag only while its enable bit is set.

A separate output-select register steers one output pin. The pin carries either the timer's divided clock, a square wave that toggles on each selected tap pulse, or an externally supplied watch clock. Software reaches every register through a small bus with a 2-bit address: writes take effect at a clock edge, and read data is combinational from the address.

Register map (all 8 bits wide):
- address 0: mode. Bits 2..0 hold the tap select, bit 3 holds the mode control, and bits 7..4 read 0.
- address 1: count. It is read-only.
- address 2: control. Bit 0 is the request flag, bit 1 is the interrupt enable, and bits 7..2 read 0.
- address 3: output select. Bit 0 is the pin select, and bits 7..1 read 1.

Top module: `prescaled_interval_timer`

## Requirements
- R1: After a synchronous active-low reset, the count reads 0x00, the mode register reads 0x00, the control register reads 0x00 and the output-select register reads 0xFE.
- R2: With mode bit 3 at 0 and tap select s (mode bits 2..0, s = 0..7), the count advances by exactly one every 2^(s+1) system clocks.
- R3: When the count is 0xFF, the next tap pulse returns it to 0x00 and sets the request flag (control bit 0) at that same clock edge.
- R4: The request flag stays set until a write to the control register has bit 0 at 0. Writing 1 to bit 0 neither sets nor clears the flag.
- R5: If an overflow and a flag-clearing write fall on the same clock edge, the flag ends up set.
- R6: The interrupt output is high exactly when the request flag is set and the interrupt enable (control bit 1) is 1.
- R7: Writing the tap select does not change the count, and the new tap paces the counter from the next clock on.
- R8: While mode bit 3 is 1, the count holds its value.
- R9: Bits 7..1 of the output-select register always read as 1 and ignore writes. Bit 0 reads back the value last written.
- R10: With output-select bit 0 at 0, the pin carries a square wave that changes level once per selected tap pulse. With bit 0 at 1, the pin follows the watch clock input.
- R11: Writes to the count address leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, taken at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| watch_clk | input | 1 | Watch clock that can be routed to the pin |
| ovf_flag | output | 1 | Sticky overflow request flag |
| irq | output | 1 | Interrupt request |
| clk_out_pin | output | 1 | Selected pin clock |

## Verification
Every register result is due one clock edge after the stimulus that causes it. This covers a write, a tap pulse and an overflow. The interrupt and the pin follow their sources combinationally within that same cycle. The bench drives inputs and samples outputs at the falling edge, so each check reads the state that the preceding rising edge produced. The tap phase is never assumed. Rate checks compare the count across windows that span a whole number of tap periods. The same-edge collision test first waits for the count to change, which fixes the tap phase, and then places the clearing write on the edge that carries the overflow.

// File: rtl/pit_pkg.sv
// Package: shared widths and register addresses for the interval timer.
// Assumes a 2-bit register address space and 8-bit data.
package pit_pkg;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 2;
    localparam int NUM_TAPS = 8;
    localparam int SEL_W    = $clog2(NUM_TAPS);

    localparam logic [ADDR_W-1:0] ADDR_MODE = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_CNT  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_OSEL = 2'd3;

    localparam int CTRL_FLAG_BIT = 0;
    localparam int CTRL_IEN_BIT  = 1;
    localparam int MODE_CTL_BIT  = SEL_W;

    typedef struct packed {
        logic             halt;
        logic [SEL_W-1:0] tap_sel;
    } mode_t;
endpackage

// File: rtl/pit_prescaler.sv
// Prescaler: a free-running divider. Tap n gives a one-cycle pulse every
// 2^(n+1) clocks, and one tap is selected at run time.
// Assumes that sel changes only at clock edges and that its new value is used from the next edge on.
module pit_prescaler #(
    parameter int TAPS  = 8,
    localparam int SW   = (TAPS > 1) ? $clog2(TAPS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] sel,
    output logic          tap_pulse
);
    logic [TAPS-1:0] div_q;
    logic [TAPS-1:0] tap_en;

    // Divider count, free running from zero after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    // Tap n fires when the low n+1 divider bits are all ones.
    for (genvar n = 0; n < TAPS; n++) begin : g_tap
        assign tap_en[n] = &div_q[n:0];
        if (n > 0) begin : g_nest
            // A slower tap fires only when every faster tap fires (R2).
            assert_tap_nested_R2: assert property (@(posedge clk) disable iff (!rst_n)
                tap_en[n] |-> tap_en[n-1]);
        end
    end

    // Selected tap drives the timer.
    always_comb tap_pulse = tap_en[sel];

    // Pulses last one cycle (R2).
    assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tap_en[0] |=> !tap_en[0]);
endmodule

// File: rtl/pit_counter.sv
// Counter core: the 8-bit up-counter, the sticky overflow flag and the
// divided clock square wave.
// Assumes tap_pulse is one cycle wide. An overflow beats a clear on the same edge.
module pit_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tap_pulse,
    input  logic         halt,
    input  logic         flag_clr,
    output logic [W-1:0] cnt,
    output logic         flag,
    output logic         tclk
);
    logic step;
    logic wrap;

    always_comb step = tap_pulse && !halt;
    always_comb wrap = step && (&cnt);

    // Count register: wraps naturally from all ones to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (step) cnt <= cnt + 1'b1;
    end

    // Sticky request flag: overflow sets it and has priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag <= 1'b0;
        else if (wrap)     flag <= 1'b1;
        else if (flag_clr) flag <= 1'b0;
    end

    // Divided clock output: toggles on every selected tap pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)         tclk <= 1'b0;
        else if (tap_pulse) tclk <= !tclk;
    end

    assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> cnt == W'($past(cnt) + 1'b1));
    assert_cnt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(cnt));
    assert_wrap_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt == '1) |=> (flag && cnt == '0));
    assert_ovf_beats_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && flag_clr) |=> flag);
    assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr) |=> flag);
endmodule

// File: rtl/pit_regs.sv
// Register file: holds the mode, the interrupt enable and the output select,
// decodes writes, muxes reads and raises the flag-clear request.
// Assumes single-cycle writes and combinational reads.
module pit_regs
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] cnt,
    input  logic              flag,
    output mode_t             mode,
    output logic              ien,
    output logic              osel,
    output logic              flag_clr
);
    localparam int MODE_W = SEL_W + 1;

    // Mode register: the tap select and the mode control bit.
    always_ff @(posedge clk) begin
        if (!rst_n)                       mode <= '0;
        else if (wr && addr == ADDR_MODE) mode <= mode_t'(wdata[MODE_W-1:0]);
    end

    // Interrupt enable bit in the control register.
    always_ff @(posedge clk) begin
        if (!rst_n)                       ien <= 1'b0;
        else if (wr && addr == ADDR_CTRL) ien <= wdata[CTRL_IEN_BIT];
    end

    // Pin select bit. The other bits of the register are not stored.
    always_ff @(posedge clk) begin
        if (!rst_n)                       osel <= 1'b0;
        else if (wr && addr == ADDR_OSEL) osel <= wdata[0];
    end

    // Clear request: a control write with a zero in the flag bit.
    always_comb flag_clr = wr && (addr == ADDR_CTRL) && !wdata[CTRL_FLAG_BIT];

    // Read mux. Reserved output-select bits read as ones.
    always_comb begin
        rdata = '0;
        unique case (addr)
            ADDR_MODE: rdata[MODE_W-1:0] = mode;
            ADDR_CNT:  rdata = cnt;
            ADDR_CTRL: begin
                rdata[CTRL_FLAG_BIT] = flag;
                rdata[CTRL_IEN_BIT]  = ien;
            end
            default:   rdata = {{(DATA_W-1){1'b1}}, osel};
        endcase
    end

    assert_osel_reserved_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_OSEL) |-> (rdata[DATA_W-1:1] == '1));
    assert_cnt_readonly_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == ADDR_CNT) |=> $stable(mode) && $stable(ien) && $stable(osel));
endmodule

// File: rtl/prescaled_interval_timer.sv
// Top level: joins the prescaler, the counter core and the register file,
// gates the interrupt and steers the output pin.
// Assumes that watch_clk is a slow clock supplied from outside and only passed through.
module prescaled_interval_timer
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              watch_clk,
    output logic              ovf_flag,
    output logic              irq,
    output logic              clk_out_pin
);
    mode_t             mode;
    logic              ien;
    logic              osel;
    logic              flag_clr;
    logic              tap_pulse;
    logic [DATA_W-1:0] cnt;
    logic              tclk;

    pit_regs u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
        .rdata(bus_rdata), .cnt(cnt), .flag(ovf_flag), .mode(mode), .ien(ien),
        .osel(osel), .flag_clr(flag_clr)
    );

    pit_prescaler #(.TAPS(NUM_TAPS)) u_pre (
        .clk(clk), .rst_n(rst_n), .sel(mode.tap_sel), .tap_pulse(tap_pulse)
    );

    pit_counter #(.W(DATA_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tap_pulse(tap_pulse), .halt(mode.halt),
        .flag_clr(flag_clr), .cnt(cnt), .flag(ovf_flag), .tclk(tclk)
    );

    // Interrupt gate: the flag reaches irq only when enabled.
    always_comb irq = ovf_flag && ien;

    // Pin steering between the divided clock and the watch clock.
    always_comb clk_out_pin = osel ? watch_clk : tclk;

    assert_irq_needs_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ovf_flag);
    assert_pin_timer_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!osel && !tap_pulse) |=> $stable(tclk));
endmodule

// File: tb/prescaled_interval_timer_test.sv
module prescaled_interval_timer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       watch_clk = 1'b0;
    logic       ovf_flag, irq, clk_out_pin;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    prescaled_interval_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .watch_clk(watch_clk),
        .ovf_flag(ovf_flag), .irq(irq), .clk_out_pin(clk_out_pin)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        @(negedge clk);
        rd(2'd1, d); check("R1 count", d, 8'h00);
        rd(2'd0, d); check("R1 mode", d, 8'h00);
        rd(2'd2, d); check("R1 ctrl", d, 8'h00);
        rd(2'd3, d); check("R1 osel", d, 8'hFE);
        check("R6 irq at reset", irq, 0);
    endtask

    task automatic t_rates();
        logic [7:0] a, b;
        for (int s = 0; s < 8; s++) begin
            wr(2'd0, 8'(s));
            @(negedge clk);
            rd(2'd1, a);
            repeat (2 * (2 << s)) @(negedge clk);
            rd(2'd1, b);
            check($sformatf("R2 tap %0d advance", s), 8'(b - a), 2);
        end
    endtask

    task automatic t_overflow();
        logic [7:0] prev, d;
        bit seen = 0;
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h00);
        rd(2'd1, prev);
        for (int i = 0; i < 2000 && !seen; i++) begin
            @(negedge clk);
            rd(2'd1, d);
            if (ovf_flag) begin
                seen = 1;
                check("R3 count after wrap", d, 8'h00);
                check("R3 count before wrap", prev, 8'hFF);
            end
            prev = d;
        end
        check("R3 flag set", seen, 1);
        check("R6 irq off while disabled", irq, 0);
        wr(2'd2, 8'h03);
        check("R4 write 1 keeps flag", ovf_flag, 1);
        check("R6 irq on", irq, 1);
        repeat (20) @(negedge clk);
        check("R4 flag sticky", ovf_flag, 1);
        wr(2'd2, 8'h02);
        check("R4 flag cleared", ovf_flag, 0);
        check("R6 irq off after clear", irq, 0);
        wr(2'd2, 8'h01);
        check("R4 write 1 does not set", ovf_flag, 0);
    endtask

    task automatic t_collision();
        logic [7:0] prev, d;
        bit hit = 0;
        wr(2'd0, 8'h00);
        rd(2'd1, prev);
        for (int i = 0; i < 2000 && !hit; i++) begin
            @(negedge clk);
            rd(2'd1, d);
            if (d == 8'hFF && prev == 8'hFE) hit = 1;
            prev = d;
        end
        // The count just changed, so the next edge has no pulse and the one after overflows.
        @(negedge clk);
        bus_addr = 2'd2; bus_wdata = 8'h00; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R5 overflow beats clear", ovf_flag, 1);
        rd(2'd1, d);
        check("R5 count wrapped", d, 8'h00);
    endtask

    task automatic t_select_change();
        logic [7:0] a, b;
        wr(2'd0, 8'h07);
        repeat (600) @(negedge clk);
        rd(2'd1, a);
        wr(2'd0, 8'h00);
        rd(2'd1, b);
        check("R7 count kept on select write", (b >= a && a != 0) ? 1 : 0, 1);
        rd(2'd1, a);
        repeat (8) @(negedge clk);
        rd(2'd1, b);
        check("R7 new tap in use", 8'(b - a), 4);
    endtask

    task automatic t_halt();
        logic [7:0] a, b;
        wr(2'd0, 8'h08);
        rd(2'd0, a);
        check("R8 mode readback", a, 8'h08);
        rd(2'd1, a);
        repeat (64) @(negedge clk);
        rd(2'd1, b);
        check("R8 count held", b, a);
        wr(2'd1, ~a);
        rd(2'd1, b);
        check("R11 count write ignored", b, a);
    endtask

    task automatic t_outsel();
        logic [7:0] d;
        int edges = 0;
        logic last;
        wr(2'd3, 8'h00);
        rd(2'd3, d); check("R9 write 0x00", d, 8'hFE);
        wr(2'd3, 8'hA5);
        rd(2'd3, d); check("R9 write 0xA5", d, 8'hFF);
        watch_clk = 1'b1; #1;
        check("R10 watch clock high", clk_out_pin, 1);
        watch_clk = 1'b0; #1;
        check("R10 watch clock low", clk_out_pin, 0);
        wr(2'd3, 8'hFE);
        rd(2'd3, d); check("R9 bit0 cleared", d, 8'hFE);
        wr(2'd0, 8'h02);
        @(negedge clk);
        last = clk_out_pin;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            if (clk_out_pin != last) edges++;
            last = clk_out_pin;
        end
        check("R10 timer clock toggles", edges, 8);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rates();
        t_overflow();
        t_collision();
        t_select_change();
        t_halt();
        t_outsel();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule